// File: doc/BRIEF.md
# Tiered Configuration Write-Lock

This block holds four 16-bit timer control registers. It stands between a simple register write port (address, data, write strobe) and the stored values. A 2-bit protection level sits inside the break/dead-time register. Each nonzero level masks writes to a fixed group of bit positions. A higher level masks everything that the lower levels mask, plus more. When a write is masked, the protected positions keep their old contents and the unprotected positions in the same word still take the new data. No error is flagged.

The level field can be written once. While it reads zero it takes writes like any other field. Once it holds a nonzero value it stays frozen until reset. Because the level shares its register with the dead-time, break and frozen-state fields, one first write can set all of them together. The protection starts with the write that follows. Reads are combinational from the address and always return the stored contents, whatever the level.

Register map (address : contents):
- 0, break: `[7:0]` dead-time code, `[9:8]` level, `[10]` frozen-when-off, `[11]` frozen-when-on, `[12]` break enable, `[13]` break polarity, `[14]` automatic output enable, `[15]` reserved.
- 1, idle: `[3:0]` idle state of the main outputs, `[7:4]` idle state of the complementary outputs, `[15:8]` reserved.
- 2, channel: `[3:0]` main polarity, `[7:4]` complementary polarity, `[11:8]` main enables, `[15:12]` complementary enables.
- 3, compare: two 8-bit slots, each with `[1:0]` select, `[2]` fast, `[3]` buffer enable, `[6:4]` compare mode, `[7]` clear enable.

Top module: `cfg_write_lock`

## Requirements
- R1: After reset, all four registers read 0x0000 and `lock_level` is 00.
- R2: At level 00, every implemented bit takes the written data. The reserved bits (address 0 bit 15, address 1 bits 15:8) always read 0.
- R3: Once the level field (address 0 bits 9:8) holds a nonzero value, later writes leave it unchanged until reset. While it holds 00 it stays writable, and writing 00 keeps it writable.
- R4: The write that first sets a nonzero level also stores the other fields of address 0 unmasked. Protection applies from the next write on.
- R5: At level 01 or above, address 0 bits 7:0, 12, 13 and 14 and address 1 bits 7:0 are protected.
- R6: At level 10 or above, address 0 bits 10 and 11 and address 2 bits 7:0 are protected as well.
- R7: At level 11, address 3 bits 6:3 and 14:11 are protected as well.
- R8: A write that covers both protected and unprotected bits updates only the unprotected bits.
- R9: `rdata` shows the register selected by `addr` in the same cycle, at any level.
- R10: A write changes only the addressed register. Without `wr_en` no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| addr | input | 2 | Register select for write and read |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Contents of the selected register |
| lock_level | output | 2 | Current protection level |
| brk_cfg | output | 16 | Break/dead-time register |
| idle_cfg | output | 16 | Idle-state register |
| chan_cfg | output | 16 | Polarity/enable register |
| cmp_cfg | output | 16 | Compare-mode register |

## Verification
The bench goes after the write that sets the level. If protection were applied to that same write, the dead-time bits written alongside the level would be lost. If the level were not sticky, a later write of 11 or 00 would raise or drop the protection. The bench also checks the tier edges: at level 10 the compare register must stay open, and at level 01 the frozen-state bits must stay open. A mask that is one tier off would freeze or release those bits. Mixed writes to the channel and compare registers show whether a design drops the whole word when it should merge the unprotected bits.

// File: rtl/cfg_write_lock.sv
module cfg_write_lock #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [1:0]    lock_level,
  output logic [DW-1:0] brk_cfg,
  output logic [DW-1:0] idle_cfg,
  output logic [DW-1:0] chan_cfg,
  output logic [DW-1:0] cmp_cfg
);
  localparam logic [DW-1:0] BRK_VALID  = 16'h7FFF;
  localparam logic [DW-1:0] IDLE_VALID = 16'h00FF;
  localparam logic [DW-1:0] BRK_T1     = 16'h73FF;
  localparam logic [DW-1:0] BRK_T2     = 16'h7FFF;
  localparam logic [DW-1:0] IDLE_T1    = 16'h00FF;
  localparam logic [DW-1:0] CHAN_T2    = 16'h00FF;
  localparam logic [DW-1:0] CMP_T3     = 16'h7878;

  logic [DW-1:0] brk_q, idle_q, chan_q, cmp_q;
  logic [DW-1:0] brk_prot, idle_prot, chan_prot, cmp_prot;
  logic [1:0]    lvl;

  assign lvl = brk_q[9:8];

  assign brk_prot  = (lvl == 2'b00) ? '0 : (lvl == 2'b01) ? BRK_T1 : BRK_T2;
  assign idle_prot = (lvl == 2'b00) ? '0 : IDLE_T1;
  assign chan_prot = lvl[1] ? CHAN_T2 : '0;
  assign cmp_prot  = (lvl == 2'b11) ? CMP_T3 : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      brk_q  <= '0;
      idle_q <= '0;
      chan_q <= '0;
      cmp_q  <= '0;
    end else if (wr_en) begin
      unique case (addr)
        2'd0: brk_q  <= (brk_q  & brk_prot)  | (wdata & ~brk_prot  & BRK_VALID);
        2'd1: idle_q <= (idle_q & idle_prot) | (wdata & ~idle_prot & IDLE_VALID);
        2'd2: chan_q <= (chan_q & chan_prot) | (wdata & ~chan_prot);
        2'd3: cmp_q  <= (cmp_q  & cmp_prot)  | (wdata & ~cmp_prot);
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (addr)
      2'd0: rdata = brk_q;
      2'd1: rdata = idle_q;
      2'd2: rdata = chan_q;
      default: rdata = cmp_q;
    endcase
  end

  assign lock_level = lvl;
  assign brk_cfg    = brk_q;
  assign idle_cfg   = idle_q;
  assign chan_cfg   = chan_q;
  assign cmp_cfg    = cmp_q;
endmodule

// File: rtl/cfg_write_lock_chk.sv
module cfg_write_lock_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [1:0]  lock_level,
  input logic [15:0] brk_cfg,
  input logic [15:0] idle_cfg,
  input logic [15:0] chan_cfg,
  input logic [15:0] cmp_cfg
);
  // R3
  level_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_level != 2'b00) |=> $stable(lock_level));
  // R5
  tier1_brk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_level != 2'b00) |=> $stable(brk_cfg & 16'h73FF) && $stable(idle_cfg[7:0]));
  // R6
  tier2_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_level[1] |=> $stable(chan_cfg[7:0]) && $stable(brk_cfg[11:10]));
  // R7
  tier3_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_level == 2'b11) |=> $stable(cmp_cfg & 16'h7878));
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable({brk_cfg, idle_cfg, chan_cfg, cmp_cfg}));
  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_cfg[15] == 1'b0) && (idle_cfg[15:8] == 8'h00));
endmodule

bind cfg_write_lock cfg_write_lock_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .lock_level(lock_level),
  .brk_cfg(brk_cfg), .idle_cfg(idle_cfg), .chan_cfg(chan_cfg), .cmp_cfg(cmp_cfg)
);

// File: tb/tb_cfg_write_lock.sv
module tb_cfg_write_lock;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata, brk_cfg, idle_cfg, chan_cfg, cmp_cfg;
  logic [1:0]  lock_level;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  cfg_write_lock dut (.*);

  // {reset_before, addr, wdata, expected read-back}
  localparam int NV = 20;
  localparam logic [34:0] VEC [NV] = '{
    {1'b1, 2'd1, 16'hFFFF, 16'h00FF},  // R2 reserved bits
    {1'b0, 2'd2, 16'h1234, 16'h1234},  // R2
    {1'b0, 2'd3, 16'hFFFF, 16'hFFFF},  // R2
    {1'b0, 2'd0, 16'h0D5A, 16'h0D5A},  // R4 level 01 with fields
    {1'b0, 2'd0, 16'h7300, 16'h015A},  // R5 R8 frozen bits open at 01
    {1'b0, 2'd1, 16'h0000, 16'h00FF},  // R5
    {1'b0, 2'd2, 16'hABCD, 16'hABCD},  // R6 open at 01
    {1'b1, 2'd0, 16'h0200, 16'h0200},  // R4 level 10
    {1'b0, 2'd0, 16'h7DFF, 16'h0200},  // R6
    {1'b0, 2'd2, 16'h5555, 16'h5500},  // R6 R8
    {1'b0, 2'd3, 16'hFFFF, 16'hFFFF},  // R7 open at 10
    {1'b0, 2'd1, 16'h0033, 16'h0000},  // R5
    {1'b1, 2'd3, 16'h8181, 16'h8181},  // R2
    {1'b0, 2'd0, 16'h0300, 16'h0300},  // R4 level 11
    {1'b0, 2'd3, 16'h7E7E, 16'h0606},  // R7 R8
    {1'b0, 2'd2, 16'hFF00, 16'hFF00},  // R8
    {1'b0, 2'd0, 16'h0000, 16'h0300},  // R3
    {1'b1, 2'd0, 16'h0000, 16'h0000},  // R3 zero keeps writable
    {1'b0, 2'd0, 16'h0100, 16'h0100},  // R3
    {1'b0, 2'd0, 16'h0300, 16'h0100}   // R3 frozen
  };

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; wr_en = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(string req, logic [1:0] a, logic [15:0] exp);
    addr = a; #1; check(req, rdata, exp);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    for (int a = 0; a < 4; a++) rd("R1", 2'(a), 16'h0000);
    check("R1", {14'd0, lock_level}, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][34]) do_reset();
      wr(VEC[i][33:32], VEC[i][31:16]);
      rd($sformatf("R5-R8 vec %0d", i), VEC[i][33:32], VEC[i][15:0]);
    end

    do_reset();
    wr(2'd2, 16'h00F0);
    rd("R10", 2'd0, 16'h0000);
    rd("R10", 2'd1, 16'h0000);
    rd("R10", 2'd3, 16'h0000);
    addr = 2'd2; wdata = 16'hFFFF; #1;
    check("R10 no strobe", chan_cfg, 16'h00F0);
    @(negedge clk); @(negedge clk);
    check("R10 no strobe", chan_cfg, 16'h00F0);

    wr(2'd0, 16'h01AB);
    check("R4", {14'd0, lock_level}, 16'h0001);
    wr(2'd0, 16'h0300);
    check("R3", {14'd0, lock_level}, 16'h0001);
    rd("R9", 2'd0, 16'h01AB);
    rd("R9", 2'd2, 16'h00F0);
    check("R9", brk_cfg, 16'h01AB);
    wr(2'd1, 16'h00FF);
    check("R5", idle_cfg, 16'h0000);
    wr(2'd3, 16'h7878);
    check("R7", cmp_cfg, 16'h7878);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule